// File: doc/BRIEF.md
# Per-Digit Carry/Borrow Flag Unit

This block is a 64-bit add/subtract datapath that also records one flag for each 4-bit digit of the sum. Each of the sixteen digit slices reports its carry-out. For subtraction the datapath forms A plus the inverted B plus one, so the carry-out of a digit is 1 exactly when no borrow was taken from it. The sixteen flags are captured in a register. They are presented inside a 64-bit status-word image, in two separate 8-bit fields. Every other bit of that image is zero.

An opcode class selects addition or subtraction and decides whether the flags are updated. A logical-completer input suppresses the update for the plain add and shift-add classes only. Operands for shift-add and divide-step arrive already prepared, so the unit only adds them. Both the result and the flags are registered under a clock enable and cleared by a synchronous active-high reset.

Top module: `digit_carry_unit`

## Requirements
- R1: On a rising edge with `en_i` high, `result_o` becomes `a_i + b_i` (mod 2^64) for class codes 0, 1, 2, 3, 6 and 7, and `a_i - b_i` (mod 2^64) for class codes 4 and 5. The new value is visible one cycle after the inputs.
- R2: After an updating add-type class (codes 0, 1, 2, 3), the flag of digit d (bits 4d+3..4d) is 1 exactly when the full 64-bit addition carries out of that digit.
- R3: After a subtract class (codes 4, 5), the flag of digit d equals the carry-out of digit d in A + ~B + 1. The flag is 1 when no borrow occurred and 0 when a borrow did.
- R4: The status image uses big-endian bit numbering, so image bit k is `status_o[63-k]`. Flags of digits 15..8 sit in image bits 24..31, which is `status_o[39:32]`, with digit 15 at `status_o[39]`. Flags of digits 7..0 sit in image bits 48..55, which is `status_o[15:8]`, with digit 7 at `status_o[15]`. All other bits of `status_o` are 0.
- R5: Class codes 0 (add), 1 (add immediate), 2 (shift-add), 3 (divide step), 4 (subtract) and 5 (subtract immediate) update the flags when `en_i` is high.
- R6: With `logical_i` high, class codes 0 and 2 leave the flags unchanged. For codes 1, 3, 4 and 5, `logical_i` has no effect.
- R7: Class codes 6 and 7 leave all sixteen flags unchanged.
- R8: While `en_i` is low, neither `result_o` nor `status_o` changes.
- R9: A rising edge with `rst_i` high clears `result_o` and `status_o` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_i | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Clock enable for result and flag capture |
| a_i | input | 64 | First operand |
| b_i | input | 64 | Second operand (subtrahend for codes 4, 5) |
| op_class_i | input | 3 | Opcode class: 0 add, 1 add-imm, 2 shift-add, 3 divide step, 4 sub, 5 sub-imm, 6/7 other |
| logical_i | input | 1 | Logical completer; suppresses flag update for codes 0 and 2 |
| result_o | output | 64 | Registered sum or difference |
| status_o | output | 64 | Status image with the captured flags in two 8-bit fields |

## Verification
All-ones plus one ripples a carry through every digit. A plus its complement produces no carry anywhere. Together these separate a real chained carry from a per-nibble sum that ignores carry-in. Equal operands and zero minus one in subtraction push the flags to all-ones and all-zeros, which exposes a missing inversion or a wrong carry-in. Single-digit carries placed in digit 0, digit 8 and digit 15 pin each field's position and direction in the status image. Random operands over all eight classes, with random logical and enable bits, exercise the update gating against a reference model kept in the bench.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
  typedef enum logic [2:0] {
    OPC_ADD   = 3'd0,
    OPC_ADDI  = 3'd1,
    OPC_SHADD = 3'd2,
    OPC_DSTEP = 3'd3,
    OPC_SUB   = 3'd4,
    OPC_SUBI  = 3'd5,
    OPC_OTH6  = 3'd6,
    OPC_OTH7  = 3'd7
  } opc_e;
endpackage

// File: rtl/dcf_class_decode.sv
module dcf_class_decode
  import dcf_pkg::*;
(
  input  opc_e op_class_i,
  input  logic logical_i,
  output logic subtract_o,
  output logic update_o
);
  always_comb begin
    subtract_o = 1'b0;
    update_o   = 1'b0;
    unique case (op_class_i)
      OPC_ADD, OPC_SHADD: update_o = ~logical_i;
      OPC_ADDI, OPC_DSTEP: update_o = 1'b1;
      OPC_SUB, OPC_SUBI: begin
        subtract_o = 1'b1;
        update_o   = 1'b1;
      end
      default: update_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/dcf_digit_adder.sv
module dcf_digit_adder #(
  parameter int DATA_W  = 64,
  parameter int DIGIT_W = 4,
  localparam int NDIG   = DATA_W / DIGIT_W
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              subtract_i,
  output logic [DATA_W-1:0] sum_o,
  output logic [NDIG-1:0]   carry_o
);
  logic [DATA_W-1:0] b_eff;
  logic [NDIG:0]     chain;

  assign b_eff    = subtract_i ? ~b_i : b_i;
  assign chain[0] = subtract_i;

  for (genvar d = 0; d < NDIG; d++) begin : g_digit
    logic [DIGIT_W:0] slice;
    assign slice = {1'b0, a_i[d*DIGIT_W +: DIGIT_W]}
                 + {1'b0, b_eff[d*DIGIT_W +: DIGIT_W]}
                 + {{DIGIT_W{1'b0}}, chain[d]};
    assign sum_o[d*DIGIT_W +: DIGIT_W] = slice[DIGIT_W-1:0];
    assign chain[d+1]                  = slice[DIGIT_W];
    assign carry_o[d]                  = slice[DIGIT_W];
  end
endmodule

// File: rtl/dcf_flag_place.sv
module dcf_flag_place #(
  parameter int DATA_W    = 64,
  parameter int NDIG      = 16,
  parameter int UPPER_POS = 24,
  parameter int LOWER_POS = 48,
  localparam int HALF     = NDIG / 2
) (
  input  logic [NDIG-1:0]   flags_i,
  output logic [DATA_W-1:0] image_o
);
  // Big-endian index k maps to vector bit DATA_W-1-k; the most significant
  // digit of each half takes the lowest index of its field.
  always_comb begin
    image_o = '0;
    for (int d = 0; d < NDIG; d++) begin
      if (d >= HALF)
        image_o[DATA_W-1-UPPER_POS-(NDIG-1-d)] = flags_i[d];
      else
        image_o[DATA_W-1-LOWER_POS-(HALF-1-d)] = flags_i[d];
    end
  end
endmodule

// File: rtl/digit_carry_unit.sv
module digit_carry_unit
  import dcf_pkg::*;
#(
  parameter int DATA_W    = 64,
  parameter int DIGIT_W   = 4,
  parameter int UPPER_POS = 24,
  parameter int LOWER_POS = 48,
  localparam int NDIG     = DATA_W / DIGIT_W
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              en_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [2:0]        op_class_i,
  input  logic              logical_i,
  output logic [DATA_W-1:0] result_o,
  output logic [DATA_W-1:0] status_o
);
  logic              is_sub, do_update;
  logic [DATA_W-1:0] sum_w, result_q;
  logic [NDIG-1:0]   carry_w, flags_q;

  dcf_class_decode u_dec (
    .op_class_i (opc_e'(op_class_i)),
    .logical_i  (logical_i),
    .subtract_o (is_sub),
    .update_o   (do_update)
  );

  dcf_digit_adder #(.DATA_W(DATA_W), .DIGIT_W(DIGIT_W)) u_add (
    .a_i        (a_i),
    .b_i        (b_i),
    .subtract_i (is_sub),
    .sum_o      (sum_w),
    .carry_o    (carry_w)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      result_q <= '0;
      flags_q  <= '0;
    end else if (en_i) begin
      result_q <= sum_w;
      if (do_update) flags_q <= carry_w;
    end
  end

  dcf_flag_place #(.DATA_W(DATA_W), .NDIG(NDIG),
                   .UPPER_POS(UPPER_POS), .LOWER_POS(LOWER_POS)) u_place (
    .flags_i (flags_q),
    .image_o (status_o)
  );

  assign result_o = result_q;

  // R8: enable low freezes both registers
  p_hold_when_idle_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    !en_i |=> ($stable(result_q) && $stable(flags_q)));

  // R7: non-updating classes keep the flags
  p_other_class_keeps_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    (en_i && op_class_i[2:1] == 2'b11) |=> $stable(flags_q));

  // R6: logical completer on add / shift-add blocks the update
  p_logical_blocks_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    (en_i && logical_i && (op_class_i == 3'd0 || op_class_i == 3'd2)) |=> $stable(flags_q));

  // R3: subtracting equal operands borrows nowhere
  p_equal_sub_no_borrow_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    (en_i && (op_class_i == 3'd4 || op_class_i == 3'd5) && a_i == b_i) |=> (flags_q == '1 && result_q == '0));

  // R2: adding an operand to its complement carries nowhere
  p_complement_add_no_carry_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    (en_i && op_class_i == 3'd1 && a_i == ~b_i) |=> (flags_q == '0 && result_q == '1));

  // R5: an update decision always writes the adder's carries
  p_update_captures_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    (en_i && do_update) |=> (flags_q == $past(carry_w)));
endmodule

// File: tb/digit_carry_unit_test.sv
module digit_carry_unit_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst, en, logical;
  logic [63:0] a, b;
  logic [2:0]  opc;
  logic [63:0] result, status;

  logic [63:0] exp_result;
  logic [15:0] exp_flags;
  int          n_checks = 0;
  int          n_fail   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  digit_carry_unit uut (
    .clk_i(clk), .rst_i(rst), .en_i(en), .a_i(a), .b_i(b),
    .op_class_i(opc), .logical_i(logical),
    .result_o(result), .status_o(status)
  );

  function automatic logic [15:0] ref_flags(input logic [63:0] x, input logic [63:0] y, input logic sub);
    logic [15:0] f;
    logic        c;
    logic [4:0]  s;
    c = sub;
    for (int d = 0; d < 16; d++) begin
      s = {1'b0, x[4*d +: 4]} + {1'b0, (sub ? ~y[4*d +: 4] : y[4*d +: 4])} + {4'd0, c};
      c = s[4];
      f[d] = c;
    end
    return f;
  endfunction

  function automatic logic [63:0] ref_image(input logic [15:0] f);
    logic [63:0] v;
    v = '0;
    v[39:32] = f[15:8];
    v[15:8]  = f[7:0];
    return v;
  endfunction

  function automatic logic ref_updates(input logic [2:0] c, input logic lg);
    case (c)
      3'd0, 3'd2: return !lg;
      3'd1, 3'd3, 3'd4, 3'd5: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] expv);
    n_checks++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic step(input logic r, input logic e, input logic [2:0] c, input logic lg,
                      input logic [63:0] x, input logic [63:0] y);
    logic sub;
    rst = r; en = e; opc = c; logical = lg; a = x; b = y;
    sub = (c == 3'd4 || c == 3'd5);
    if (r) begin
      exp_result = '0;
      exp_flags  = '0;
    end else if (e) begin
      exp_result = sub ? x - y : x + y;
      if (ref_updates(c, lg)) exp_flags = ref_flags(x, y, sub);
    end
    @(posedge clk);
    #1;
  endtask

  task automatic check_both(input string req);
    check({req, " result"}, result, exp_result);
    check({req, " status"}, status, ref_image(exp_flags));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL R1 watchdog actual=hung expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    exp_result = '0; exp_flags = '0;
    rst = 1'b1; en = 1'b0; opc = '0; logical = 1'b0; a = '0; b = '0;
    seed = $urandom(32'd1234);
    @(negedge clk);
    step(1'b1, 1'b1, 3'd0, 1'b0, 64'h5, 64'h7);
    check("R9 reset result", result, 64'h0);
    check("R9 reset status", status, 64'h0);

    // R2: carry ripples through all digits
    step(1'b0, 1'b1, 3'd0, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1);
    check("R1 wrap result", result, 64'h0);
    check("R2 all carries", status, 64'h0000_00FF_0000_FF00);
    // R2: complement, no carry
    step(1'b0, 1'b1, 3'd1, 1'b0, 64'h0123_4567_89AB_CDEF, ~64'h0123_4567_89AB_CDEF);
    check("R2 no carries", status, 64'h0);
    // R3: equal subtract
    step(1'b0, 1'b1, 3'd4, 1'b0, 64'hDEAD_BEEF_0BAD_F00D, 64'hDEAD_BEEF_0BAD_F00D);
    check("R3 equal sub result", result, 64'h0);
    check("R3 no borrow flags", status, 64'h0000_00FF_0000_FF00);
    // R3: borrow everywhere
    step(1'b0, 1'b1, 3'd5, 1'b0, 64'h0, 64'h1);
    check("R3 borrow result", result, 64'hFFFF_FFFF_FFFF_FFFF);
    check("R3 all borrows", status, 64'h0);
    // R4: digit 0 -> bit 8
    step(1'b0, 1'b1, 3'd0, 1'b0, 64'h0F, 64'h01);
    check("R4 digit0 position", status, 64'h0000_0000_0000_0100);
    // R4: digit 8 -> bit 32
    step(1'b0, 1'b1, 3'd3, 1'b0, 64'h0000_000F_0000_0000, 64'h0000_0001_0000_0000);
    check("R4 digit8 position", status, 64'h0000_0001_0000_0000);
    // R4: digit 15 -> bit 39
    step(1'b0, 1'b1, 3'd2, 1'b0, 64'hF000_0000_0000_0000, 64'h1000_0000_0000_0000);
    check("R4 digit15 position", status, 64'h0000_0080_0000_0000);
    // R4: digit 7 -> bit 15
    step(1'b0, 1'b1, 3'd0, 1'b0, 64'h0000_0000_F000_0000, 64'h0000_0000_1000_0000);
    check("R4 digit7 position", status, 64'h0000_0000_0000_8000);
    // R6: logical add holds, logical add-imm updates
    step(1'b0, 1'b1, 3'd0, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1);
    check_both("R6 logical add hold");
    step(1'b0, 1'b1, 3'd2, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1);
    check_both("R6 logical shadd hold");
    step(1'b0, 1'b1, 3'd1, 1'b1, 64'hFF, 64'h01);
    check_both("R6 logical addi updates");
    step(1'b0, 1'b1, 3'd4, 1'b1, 64'h10, 64'h1);
    check_both("R6 logical sub updates");
    // R7: other classes hold
    step(1'b0, 1'b1, 3'd6, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF);
    check_both("R7 class6 hold");
    step(1'b0, 1'b1, 3'd7, 1'b0, 64'h0, 64'h1);
    check_both("R7 class7 hold");
    // R8: enable low
    step(1'b0, 1'b0, 3'd0, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1);
    check_both("R8 idle hold");
    // R5: random mix
    for (int i = 0; i < 400; i++) begin
      step(1'b0, ($urandom % 4) != 0, 3'($urandom % 8), 1'($urandom % 2),
           {$urandom, $urandom}, {$urandom, $urandom});
      check_both("R5 random");
    end
    // R9: reset mid-run
    step(1'b0, 1'b1, 3'd0, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1);
    step(1'b1, 1'b1, 3'd0, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1);
    check("R9 reset result late", result, 64'h0);
    check("R9 reset status late", status, 64'h0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule